// File: doc/BRIEF.md
# In-Order Retirement Queue with Rename Release

This block keeps every dispatched instruction in a circular queue in program order until the instruction is architecturally complete. When an instruction is dispatched, the block stores three things for it: its destination register number, the index of the rename-buffer slot that will hold its result, and a flag that marks it as a store. It returns the queue slot it chose as a tag. The execution side later broadcasts that tag on the result bus to mark the entry finished.

Entries leave the queue only from the oldest end, only when they are finished, and at most one per cycle. A non-store leaves by copying the value in its rename slot into the architected register file and releasing that slot in the same cycle. A store leaves by handing the rename-slot value to an external store buffer over a valid/ready handshake, and it also releases its slot. It does not write the register file.

Occupancy is tracked by a count register and a three-state occupancy machine. The states are EMPTY, PARTIAL and FULL. The transitions are: EMPTY→PARTIAL on a dispatch; PARTIAL→FULL on a dispatch with no retirement when one slot is left; PARTIAL→EMPTY on a retirement with no dispatch when one entry is left; FULL→PARTIAL on a retirement. Every other case stays in the current state.

Top module: `retire_order_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `disp_ready_o`=1), and `rf_wr_en_o`, `sb_valid_o` and `ren_free_o` are all 0.
- R2: Each accepted dispatch returns on `disp_tag_o` the next slot index in sequence. The first tag after reset is 0, and the index wraps from DEPTH-1 back to 0.
- R3: With DEPTH entries held, `disp_ready_o` is 0, and a dispatch offered in that state is ignored. It neither takes a slot nor advances the tag sequence.
- R4: An entry does not retire until a result broadcast (`wb_valid_i`=1) carrying its tag has been seen. The earliest retirement is the cycle after that broadcast.
- R5: Retirement is strictly in dispatch order. A finished entry waits while any older entry is unfinished.
- R6: A non-store retires with `rf_wr_en_o`=1, `rf_wr_addr_o` equal to its destination register, `rf_wr_data_o` equal to `ren_rd_data_i`, and `ren_rd_idx_o`/`ren_free_idx_o` equal to its rename index. `ren_free_o` is 1 in that same cycle.
- R7: A finished store at the head raises `sb_valid_o` with `sb_data_o` equal to `ren_rd_data_i`. It retires when `sb_ready_i`=1, which releases its rename slot, and it never asserts `rf_wr_en_o`.
- R8: While a finished store at the head sees `sb_ready_i`=0, nothing retires and `sb_valid_o` stays 1.
- R9: At most one entry retires per cycle. A run of N finished entries at the head retires over N consecutive cycles.
- R10: `empty_o` returns to 1 in the cycle after the last held entry retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dest_i | input | AREG_W | Destination architected register |
| disp_ren_i | input | REN_W | Rename-buffer slot allocated for the result |
| disp_store_i | input | 1 | Instruction is a store |
| disp_ready_o | output | 1 | Queue can accept a dispatch (not full) |
| disp_tag_o | output | IDX_W | Slot index given to the dispatched instruction |
| empty_o | output | 1 | Queue holds no entries |
| wb_valid_i | input | 1 | Result broadcast valid |
| wb_tag_i | input | IDX_W | Tag of the instruction that finished |
| ren_rd_idx_o | output | REN_W | Rename slot of the head entry, for reading its value |
| ren_rd_data_i | input | DATA_W | Value read from that rename slot |
| rf_wr_en_o | output | 1 | Architected register write strobe |
| rf_wr_addr_o | output | AREG_W | Architected register written |
| rf_wr_data_o | output | DATA_W | Value written |
| ren_free_o | output | 1 | Release a rename slot |
| ren_free_idx_o | output | REN_W | Rename slot released |
| sb_valid_o | output | 1 | Store offered to the store buffer |
| sb_data_o | output | DATA_W | Store value |
| sb_ready_i | input | 1 | Store buffer accepts |

## Verification
A wrong head pointer or a stale finished flag first shows up as a retirement with the wrong destination or rename index. The scoreboard catches it in the same cycle, because every retirement is compared against the queue of dispatched items in program order. A drifting count or a wrong occupancy state shows within one dispatch as a wrong `disp_ready_o`, a wrong `empty_o` or a skipped tag. An ignored dispatch that was in fact accepted shows up later as an off-by-one tag once space is freed.

// File: rtl/roq_pkg.sv
package roq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/roq_occupancy.sv
module roq_occupancy
    import roq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [IDX_W-1:0] head_q, tail_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_i) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push_i && !pop_i && count_q == CNT_LAST)
                    state_d = OCC_FULL;
                else if (pop_i && !push_i && count_q == CNT_W'(1))
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_i && !push_i) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // outputs of the machine
    always_comb begin
        empty_o = (state_q == OCC_EMPTY);
        full_o  = (state_q == OCC_FULL);
    end

    always_comb begin
        count_d = count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            count_q <= count_d;
            if (push_i) tail_q <= tail_q + 1'b1;
            if (pop_i)  head_q <= head_q + 1'b1;
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> count_q != CNT_FULL);

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> count_q != '0);

    a_r1_state_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == OCC_EMPTY) == (count_q == '0)) &&
        ((state_q == OCC_FULL) == (count_q == CNT_FULL)));

    a_r2_pointer_gap: assert property (@(posedge clk) disable iff (!rst_n)
        IDX_W'(tail_q - head_q) == IDX_W'(count_q));

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count_q == $past(count_q) + CNT_W'($past(push_i)) - CNT_W'($past(pop_i)));
endmodule

// File: rtl/roq_entry_array.sv
module roq_entry_array #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int AREG_W = 5,
    parameter int REN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [IDX_W-1:0]  alloc_idx_i,
    input  logic [AREG_W-1:0] alloc_dest_i,
    input  logic [REN_W-1:0]  alloc_ren_i,
    input  logic              alloc_store_i,
    input  logic              bcast_i,
    input  logic [IDX_W-1:0]  bcast_idx_i,
    input  logic              release_i,
    input  logic [IDX_W-1:0]  head_idx_i,
    output logic              head_live_o,
    output logic              head_done_o,
    output logic              head_store_o,
    output logic [AREG_W-1:0] head_dest_o,
    output logic [REN_W-1:0]  head_ren_o
);
    logic [DEPTH-1:0] live_q, done_q, store_q;
    logic [AREG_W-1:0] dest_q [DEPTH];
    logic [REN_W-1:0]  ren_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_alloc, hit_bcast, hit_rel;
        assign hit_alloc = alloc_i   && (alloc_idx_i == IDX_W'(g));
        assign hit_bcast = bcast_i   && (bcast_idx_i == IDX_W'(g));
        assign hit_rel   = release_i && (head_idx_i  == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q[g]  <= 1'b0;
                done_q[g]  <= 1'b0;
                store_q[g] <= 1'b0;
                dest_q[g]  <= '0;
                ren_q[g]   <= '0;
            end else if (hit_alloc) begin
                live_q[g]  <= 1'b1;
                done_q[g]  <= 1'b0;
                store_q[g] <= alloc_store_i;
                dest_q[g]  <= alloc_dest_i;
                ren_q[g]   <= alloc_ren_i;
            end else if (hit_rel) begin
                live_q[g]  <= 1'b0;
                done_q[g]  <= 1'b0;
            end else if (hit_bcast && live_q[g]) begin
                done_q[g]  <= 1'b1;
            end
        end
    end

    assign head_live_o  = live_q[head_idx_i];
    assign head_done_o  = done_q[head_idx_i];
    assign head_store_o = store_q[head_idx_i];
    assign head_dest_o  = dest_q[head_idx_i];
    assign head_ren_o   = ren_q[head_idx_i];

    // R4: a slot being released must be occupied and finished
    a_r4_release_finished: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> live_q[head_idx_i] && done_q[head_idx_i]);

    a_r3_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !live_q[alloc_idx_i]);
endmodule

// File: rtl/roq_retire_ctrl.sv
module roq_retire_ctrl #(
    parameter int AREG_W = 5,
    parameter int REN_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              empty_i,
    input  logic              head_live_i,
    input  logic              head_done_i,
    input  logic              head_store_i,
    input  logic [AREG_W-1:0] head_dest_i,
    input  logic [REN_W-1:0]  head_ren_i,
    input  logic [DATA_W-1:0] ren_data_i,
    input  logic              sb_ready_i,
    output logic              retire_o,
    output logic [REN_W-1:0]  ren_rd_idx_o,
    output logic              rf_wr_en_o,
    output logic [AREG_W-1:0] rf_wr_addr_o,
    output logic [DATA_W-1:0] rf_wr_data_o,
    output logic              ren_free_o,
    output logic [REN_W-1:0]  ren_free_idx_o,
    output logic              sb_valid_o,
    output logic [DATA_W-1:0] sb_data_o
);
    logic head_ready;

    always_comb begin
        head_ready     = !empty_i && head_live_i && head_done_i;
        sb_valid_o     = head_ready && head_store_i;
        retire_o       = head_ready && (!head_store_i || sb_ready_i);
        rf_wr_en_o     = retire_o && !head_store_i;
        rf_wr_addr_o   = head_dest_i;
        rf_wr_data_o   = ren_data_i;
        ren_rd_idx_o   = head_ren_i;
        ren_free_o     = retire_o;
        ren_free_idx_o = head_ren_i;
        sb_data_o      = ren_data_i;
    end

    a_r7_store_skips_rf: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid_o |-> !rf_wr_en_o);

    a_r8_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid_o && !sb_ready_i) |=> sb_valid_o && $stable(ren_rd_idx_o));

    a_r10_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |-> !ren_free_o && !sb_valid_o);
endmodule

// File: rtl/retire_order_queue.sv
module retire_order_queue #(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int REN_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid_i,
    input  logic [AREG_W-1:0] disp_dest_i,
    input  logic [REN_W-1:0]  disp_ren_i,
    input  logic              disp_store_i,
    output logic              disp_ready_o,
    output logic [IDX_W-1:0]  disp_tag_o,
    output logic              empty_o,
    input  logic              wb_valid_i,
    input  logic [IDX_W-1:0]  wb_tag_i,
    output logic [REN_W-1:0]  ren_rd_idx_o,
    input  logic [DATA_W-1:0] ren_rd_data_i,
    output logic              rf_wr_en_o,
    output logic [AREG_W-1:0] rf_wr_addr_o,
    output logic [DATA_W-1:0] rf_wr_data_o,
    output logic              ren_free_o,
    output logic [REN_W-1:0]  ren_free_idx_o,
    output logic              sb_valid_o,
    output logic [DATA_W-1:0] sb_data_o,
    input  logic              sb_ready_i
);
    logic             full, empty, push, pop;
    logic [IDX_W-1:0] head, tail;
    logic             h_live, h_done, h_store;
    logic [AREG_W-1:0] h_dest;
    logic [REN_W-1:0]  h_ren;

    assign push         = disp_valid_i && !full;
    assign disp_ready_o = !full;
    assign disp_tag_o   = tail;
    assign empty_o      = empty;

    roq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .head_o(head), .tail_o(tail), .empty_o(empty), .full_o(full)
    );

    roq_entry_array #(.DEPTH(DEPTH), .AREG_W(AREG_W), .REN_W(REN_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(push), .alloc_idx_i(tail), .alloc_dest_i(disp_dest_i),
        .alloc_ren_i(disp_ren_i), .alloc_store_i(disp_store_i),
        .bcast_i(wb_valid_i), .bcast_idx_i(wb_tag_i),
        .release_i(pop), .head_idx_i(head),
        .head_live_o(h_live), .head_done_o(h_done), .head_store_o(h_store),
        .head_dest_o(h_dest), .head_ren_o(h_ren)
    );

    roq_retire_ctrl #(.AREG_W(AREG_W), .REN_W(REN_W), .DATA_W(DATA_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .empty_i(empty),
        .head_live_i(h_live), .head_done_i(h_done), .head_store_i(h_store),
        .head_dest_i(h_dest), .head_ren_i(h_ren), .ren_data_i(ren_rd_data_i),
        .sb_ready_i(sb_ready_i), .retire_o(pop), .ren_rd_idx_o(ren_rd_idx_o),
        .rf_wr_en_o(rf_wr_en_o), .rf_wr_addr_o(rf_wr_addr_o),
        .rf_wr_data_o(rf_wr_data_o), .ren_free_o(ren_free_o),
        .ren_free_idx_o(ren_free_idx_o), .sb_valid_o(sb_valid_o),
        .sb_data_o(sb_data_o)
    );

    // R5/R9: the tag handed out stays ahead of retirement; a full queue refuses dispatch
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !disp_ready_o && !empty_o);
endmodule

// File: tb/retire_order_queue_test.sv
module retire_order_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [4:0]  disp_dest = '0;
    logic [3:0]  disp_ren = '0;
    logic        disp_store = 1'b0;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        empty;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [3:0]  ren_rd_idx;
    logic [31:0] ren_rd_data;
    logic        rf_wr_en;
    logic [4:0]  rf_wr_addr;
    logic [31:0] rf_wr_data;
    logic        ren_free;
    logic [3:0]  ren_free_idx;
    logic        sb_valid;
    logic [31:0] sb_data;
    logic        sb_ready = 1'b1;

    int total = 0;
    int bad = 0;
    int n_ret = 0;
    logic [9:0] expq[$];

    always #10 clk = ~clk;

    assign ren_rd_data = 32'hC0DE_0000 | (32'(ren_rd_idx) * 32'd17);

    retire_order_queue uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid_i(disp_valid), .disp_dest_i(disp_dest), .disp_ren_i(disp_ren),
        .disp_store_i(disp_store), .disp_ready_o(disp_ready), .disp_tag_o(disp_tag),
        .empty_o(empty), .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
        .ren_rd_idx_o(ren_rd_idx), .ren_rd_data_i(ren_rd_data),
        .rf_wr_en_o(rf_wr_en), .rf_wr_addr_o(rf_wr_addr), .rf_wr_data_o(rf_wr_data),
        .ren_free_o(ren_free), .ren_free_idx_o(ren_free_idx),
        .sb_valid_o(sb_valid), .sb_data_o(sb_data), .sb_ready_i(sb_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ren_val(input logic [3:0] idx);
        return 32'hC0DE_0000 | (32'(idx) * 32'd17);
    endfunction

    // driver: offers one dispatch and records the expected retirement
    task automatic dispatch(input logic [4:0] d, input logic [3:0] r, input bit st, input logic [2:0] exp_tag);
        @(negedge clk);
        disp_valid = 1'b1; disp_dest = d; disp_ren = r; disp_store = st;
        #2;
        chk(disp_ready, "R3 ready on dispatch", 32'(disp_ready), 1);
        chk(disp_tag == exp_tag, "R2 tag sequence", 32'(disp_tag), 32'(exp_tag));
        if (disp_ready) expq.push_back({st, st ? 5'd0 : d, r});
        @(posedge clk); #1;
        disp_valid = 1'b0;
    endtask

    task automatic finish_tag(input logic [2:0] t);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = t;
        @(posedge clk); #1;
        wb_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard on every retirement
    always begin
        @(negedge clk); #5;
        if (rst_n) begin
            if (rf_wr_en && sb_valid)
                chk(1'b0, "R7 store and rf write together", 1, 0);
            if (rf_wr_en || (sb_valid && sb_ready)) begin
                logic [9:0] exp_i, got;
                n_ret++;
                chk(ren_free, "R6 R7 rename release with retire", 32'(ren_free), 1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected retirement", 32'(ren_free_idx), 0);
                end else begin
                    exp_i = expq.pop_front();
                    got = rf_wr_en ? {1'b0, rf_wr_addr, ren_free_idx} : {1'b1, 5'd0, ren_free_idx};
                    chk(got == exp_i, "R5 R6 R7 retirement order and fields", 32'(got), 32'(exp_i));
                    chk(ren_rd_idx == exp_i[3:0], "R6 rename read index", 32'(ren_rd_idx), 32'(exp_i[3:0]));
                    if (rf_wr_en)
                        chk(rf_wr_data == ren_val(exp_i[3:0]), "R6 rf data", rf_wr_data, ren_val(exp_i[3:0]));
                    else
                        chk(sb_data == ren_val(exp_i[3:0]), "R7 store data", sb_data, ren_val(exp_i[3:0]));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        chk(empty == 1'b1, "R1 empty after reset", 32'(empty), 1);
        chk(disp_ready == 1'b1, "R1 ready after reset", 32'(disp_ready), 1);
        chk(!rf_wr_en && !sb_valid && !ren_free, "R1 outputs idle", 32'({rf_wr_en, sb_valid, ren_free}), 0);
        @(negedge clk); rst_n = 1'b1;

        // reg, reg, store
        dispatch(5'd3, 4'd2, 1'b0, 3'd0);
        dispatch(5'd7, 4'd9, 1'b0, 3'd1);
        dispatch(5'd0, 4'd4, 1'b1, 3'd2);
        repeat (2) @(posedge clk); #1;
        chk(n_ret == 0, "R4 nothing retires before broadcast", 32'(n_ret), 0);
        finish_tag(3'd0);
        repeat (2) @(posedge clk); #1;
        chk(n_ret == 1, "R4 retire after broadcast", 32'(n_ret), 1);
        finish_tag(3'd2);
        repeat (3) @(posedge clk); #1;
        chk(n_ret == 1, "R5 younger waits for older", 32'(n_ret), 1);
        finish_tag(3'd1);
        repeat (3) @(posedge clk); #1;
        chk(n_ret == 3, "R5 in-order drain", 32'(n_ret), 3);

        // store stall
        @(negedge clk); sb_ready = 1'b0;
        dispatch(5'd0, 4'd11, 1'b1, 3'd3);
        dispatch(5'd12, 4'd5, 1'b0, 3'd4);
        finish_tag(3'd4);
        finish_tag(3'd3);
        repeat (4) @(posedge clk);
        @(negedge clk); #6;
        chk(n_ret == 3, "R8 no retire while store buffer busy", 32'(n_ret), 3);
        chk(sb_valid == 1'b1, "R8 store still offered", 32'(sb_valid), 1);
        chk(rf_wr_en == 1'b0, "R8 no rf write behind stalled store", 32'(rf_wr_en), 0);
        @(negedge clk); sb_ready = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk(n_ret == 5, "R8 drain after ready", 32'(n_ret), 5);

        // fill to full with wrap
        for (int k = 0; k < 8; k++)
            dispatch(5'(k + 8), 4'(k), 1'b0, 3'((5 + k) % 8));
        #2;
        chk(disp_ready == 1'b0, "R3 ready low when full", 32'(disp_ready), 0);
        @(negedge clk);
        disp_valid = 1'b1; disp_dest = 5'd31; disp_ren = 4'd15; disp_store = 1'b0;
        @(posedge clk); #1;
        disp_valid = 1'b0;
        chk(empty == 1'b0, "R3 still holding entries", 32'(empty), 0);

        // finish in reverse order; head finishes last
        for (int k = 0; k < 7; k++)
            finish_tag(3'((5 + 7 - k) % 8));
        repeat (2) @(posedge clk); #1;
        chk(n_ret == 5, "R5 head blocks finished younger", 32'(n_ret), 5);
        base = n_ret;
        finish_tag(3'd5);
        repeat (7) @(posedge clk); #1;
        chk(n_ret == base + 7, "R9 one per cycle", 32'(n_ret), 32'(base + 7));
        chk(empty == 1'b0, "R10 not empty before last", 32'(empty), 0);
        @(posedge clk); #1;
        chk(n_ret == base + 8, "R9 consecutive drain", 32'(n_ret), 32'(base + 8));
        chk(empty == 1'b1, "R10 empty after last retire", 32'(empty), 1);

        // ignored dispatch must not have taken tag 5
        dispatch(5'd20, 4'd14, 1'b0, 3'd5);
        finish_tag(3'd5);
        repeat (2) @(posedge clk); #1;
        chk(n_ret == base + 9, "R3 ignored dispatch left no entry", 32'(n_ret), 32'(base + 9));
        chk(expq.size() == 0, "R5 scoreboard drained", 32'(expq.size()), 0);
        chk(empty == 1'b1, "R10 empty at end", 32'(empty), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule